// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts, during the fetch cycle, whether the instruction at the fetch address is a branch that will be taken and, if so, where it goes. The fetch stage presents its address and reads back three results in the same cycle: a hit flag, a taken prediction and a target address. The buffer holds 256 entries arranged as 64 sets of 4 ways. Each entry records a tag taken from the branch address, the destination seen the last time the branch was taken, and a 2-bit saturating history counter.

Training happens only at execute time. The execute stage reports each resolved branch through an update port with the branch address, the real outcome and the real target. A branch already held in the buffer has its counter moved toward the outcome. A taken branch that is not held gets a new entry. A not-taken branch that is not held leaves the buffer alone. Recovery from a wrong prediction is handled outside this block.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a taken branch is written in.
- R2: Address bits [7:2] pick the set and bits [31:8] form the tag. A lookup hits only when a valid way in that set holds the same tag. An address with the same set bits and a different tag misses.
- R3: A taken update that misses allocates an entry with the counter set to 2 and the update target stored, so the next lookup of that address hits, predicts taken and returns that target.
- R4: A not-taken update that misses changes nothing: a later lookup of that address still misses.
- R5: An update that hits moves the 2-bit counter up on taken and down on not-taken, saturating at 3 and at 0. The lookup predicts taken exactly when counter bit 1 is set.
- R6: The stored target is replaced only by a taken update. A not-taken update keeps the old target, and a hit returns the stored target whatever the direction.
- R7: Allocation fills the lowest-numbered invalid way first. If the set is full, it replaces the way named by a 3-bit tree pseudo-LRU, which is touched by every write to the set.
- R8: The lookup is combinational. An update is seen by lookups from the cycle after the one in which up_valid is high, and not in that cycle.
- R9: On a miss, lk_taken is 0 and lk_target is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | A valid entry matches lk_pc |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_target | output | 32 | Predicted destination address |
| up_valid | input | 1 | A resolved branch is being reported |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome (1 = taken) |
| up_target | input | 32 | Actual destination address |

## Verification
The lookup results are due in the same cycle as lk_pc. The monitor therefore samples them 2 ns after the falling edge at which the driver changed the address, well before the next rising edge. An update takes effect at the rising edge that follows its falling-edge drive. For that reason, the lookups that check it are queued for the next cycle or later. One check places a lookup of the same address in the update cycle itself, where the old state is expected. Replacement order is checked by filling a set and then touching one way, so that the pseudo-LRU must pick a particular way, and by watching which older branch then misses.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 64,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [2:0]        lru_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_q [SETS][WAYS];
  logic [1:0]        ctr_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAYS-1:0]  lk_m, up_m;
  logic [1:0]       lk_way, up_way, free_way, victim, wr_way;
  logic             up_hit, has_free, do_wr;

  assign lk_idx = lk_pc[OFS_W +: IDX_W];
  assign lk_tag = lk_pc[ADDR_W-1 -: TAG_W];
  assign up_idx = up_pc[OFS_W +: IDX_W];
  assign up_tag = up_pc[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_m[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    assign up_m[w] = vld_q[up_idx][w] && (tag_q[up_idx][w] == up_tag);
  end

  always_comb begin
    lk_way   = '0;
    up_way   = '0;
    free_way = '0;
    has_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_m[w]) lk_way = w[1:0];
      if (up_m[w]) up_way = w[1:0];
      if (!vld_q[up_idx][w]) begin
        free_way = w[1:0];
        has_free = 1'b1;
      end
    end
  end

  // tree bits: [0] 1 -> victim in ways 2/3, [1] 1 -> way 1, [2] 1 -> way 3
  function automatic logic [1:0] lru_pick(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic logic [2:0] lru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    if (w[1]) begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end else begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end
    return n;
  endfunction

  function automatic logic [1:0] bump(input logic [1:0] c, input logic tk);
    if (tk) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  assign up_hit = |up_m;
  assign victim = has_free ? free_way : lru_pick(lru_q[up_idx]);
  assign wr_way = up_hit ? up_way : victim;
  assign do_wr  = up_valid && (up_hit || up_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= '0;
      end
    end else if (do_wr) begin
      vld_q[up_idx][wr_way] <= 1'b1;
      lru_q[up_idx]         <= lru_touch(lru_q[up_idx], wr_way);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_q[up_idx][wr_way] <= up_tag;
      ctr_q[up_idx][wr_way] <= up_hit ? bump(ctr_q[up_idx][up_way], up_taken) : 2'd2;
      if (up_taken) tgt_q[up_idx][wr_way] <= up_target;
    end
  end

  assign lk_hit    = |lk_m;
  assign lk_taken  = lk_hit && ctr_q[lk_idx][lk_way][1];
  assign lk_target = lk_hit ? tgt_q[lk_idx][lk_way] : '0;

  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_m)); // R2
  AST_ALLOC_WEAK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_hit && up_taken |=> ctr_q[$past(up_idx)][$past(wr_way)] == 2'd2); // R3
  AST_NT_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_hit && !up_taken |=> vld_q[$past(up_idx)] == $past(vld_q[up_idx])); // R4
  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_hit && up_taken && ctr_q[up_idx][up_way] == 2'd3
    |=> ctr_q[$past(up_idx)][$past(up_way)] == 2'd3); // R5
  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_hit && !up_taken && ctr_q[up_idx][up_way] == 2'd0
    |=> ctr_q[$past(up_idx)][$past(up_way)] == 2'd0); // R5
  AST_TGT_KEPT_NT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_hit && !up_taken
    |=> tgt_q[$past(up_idx)][$past(up_way)] == $past(tgt_q[up_idx][up_way])); // R6
  AST_TAKEN_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_taken |=> vld_q[$past(up_idx)][$past(wr_way)]
      && tgt_q[$past(up_idx)][$past(wr_way)] == $past(up_target)); // R8
endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] lk_pc = '0, up_pc = '0, up_target = '0, lk_target;
  logic up_valid = 1'b0, up_taken = 1'b0, lk_hit, lk_taken;
  int total = 0, bad = 0;
  bit done = 0;
  logic [33:0] exp_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  btb_predictor uut (.clk, .rst_n, .lk_pc, .lk_hit, .lk_taken, .lk_target,
                     .up_valid, .up_pc, .up_taken, .up_target);

  task automatic cyc(input logic uv, input logic [31:0] upc, input logic ut,
                     input logic [31:0] utg, input logic lv, input logic [31:0] lpc,
                     input logic eh, input logic etk, input logic [31:0] etg, input string rq);
    @(negedge clk);
    up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg; lk_pc = lpc;
    if (lv) begin
      exp_q.push_back({eh, etk, etg});
      req_q.push_back(rq);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    cyc(1, pc, tk, tg, 0, 0, 0, 0, 0, "");
  endtask

  task automatic look(input logic [31:0] pc, input logic eh, input logic etk,
                      input logic [31:0] etg, input string rq);
    cyc(0, 0, 0, 0, 1, pc, eh, etk, etg, rq);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; up_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : monitor
    logic [33:0] e;
    string r;
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        total++;
        if ({lk_hit, lk_taken, lk_target} !== e) begin
          bad++;
          $display("FAIL %s: got hit=%0b taken=%0b target=%h, expected hit=%0b taken=%0b target=%h",
                   r, lk_hit, lk_taken, lk_target, e[33], e[32], e[31:0]);
        end
      end
    end
  end

  localparam logic [31:0] A = 32'h1040, B = 32'h2040, C = 32'h3040, D = 32'h4040,
                          E = 32'h5040, F = 32'h6040;

  initial begin : driver
    do_reset();
    look(A, 0, 0, 0, "R1 reset miss");
    look(0, 0, 0, 0, "R1 R9 reset miss zero");
    upd(A, 0, 32'h9999);
    look(A, 0, 0, 0, "R4 not-taken miss no alloc");
    cyc(1, A, 1, 32'hA000, 1, A, 0, 0, 0, "R8 same-cycle lookup sees old state");
    look(A, 1, 1, 32'hA000, "R3 R8 allocated taken");
    look(32'h1044, 0, 0, 0, "R2 other set misses");
    look(32'h11040, 0, 0, 0, "R2 R9 other tag misses");
    upd(A, 0, 32'h1234);
    look(A, 1, 0, 32'hA000, "R5 R6 ctr1 not-taken, target kept");
    upd(A, 1, 32'hA100);
    look(A, 1, 1, 32'hA100, "R5 R6 ctr2 taken, target replaced");
    upd(A, 1, 32'hA100);
    upd(A, 1, 32'hA100);
    upd(A, 0, 32'h5555);
    look(A, 1, 1, 32'hA100, "R5 saturate at 3 then down to 2");
    upd(A, 0, 32'h5555);
    look(A, 1, 0, 32'hA100, "R5 ctr1 not taken");
    upd(A, 0, 32'h5555);
    upd(A, 0, 32'h5555);
    upd(A, 1, 32'hA100);
    look(A, 1, 0, 32'hA100, "R5 saturate at 0 then up to 1");
    upd(B, 1, 32'hB000);
    upd(C, 1, 32'hC000);
    upd(D, 1, 32'hD000);
    look(B, 1, 1, 32'hB000, "R7 fill free way B");
    look(C, 1, 1, 32'hC000, "R7 fill free way C");
    look(D, 1, 1, 32'hD000, "R7 fill free way D");
    look(A, 1, 0, 32'hA100, "R7 A kept while ways were free");
    upd(A, 1, 32'hA100);
    upd(E, 1, 32'hE000);
    look(C, 0, 0, 0, "R7 plru replaced C");
    look(E, 1, 1, 32'hE000, "R7 E allocated");
    look(A, 1, 1, 32'hA100, "R7 A kept");
    look(B, 1, 1, 32'hB000, "R7 B kept");
    look(D, 1, 1, 32'hD000, "R7 D kept");
    upd(F, 1, 32'hF000);
    look(B, 0, 0, 0, "R7 plru replaced B");
    look(F, 1, 1, 32'hF000, "R7 F allocated");
    do_reset();
    look(A, 0, 0, 0, "R1 second reset clears");
    look(F, 0, 0, 0, "R1 R9 second reset clears");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got no end, expected end of run");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule